// File: doc/BRIEF.md
# Sink Capability Byte Store with Presence Flags

This block holds the capability bytes that describe an attached display sink's audio abilities. A display controller fills the bytes. An audio codec reads them. The host side loads the store one byte at a time. Each load uses a single 32-bit write to the byte-load word address (0xBC). That write carries the target index in bits [15:8] and the byte value in bits [7:0]. The store always has 96 locations. The reading side always treats it as 96 bytes long, so the host writes every location and fills bytes beyond the real data with zero.

A two-bit presence register sits at the adjacent word address (0xBD). Bit 0 means a sink is attached and bit 1 means the stored bytes may be used. The host sets both bits after a complete load. It writes zero to the register when the sink is disconnected.

The presence register is held by a four-state machine. The states are GONE (00), ATTACHED (01, present only), STALE (10, valid only) and READY (11). Any presence write moves the machine straight to the state named by the written bits. From every state, the transition goes to the state that those two bits encode. A transition that changes the state sends a one-cycle notify pulse toward the codec. The codec reads a byte by index and gets the result one cycle later. It reads zero while the valid bit is clear.

Top module: `eld_buffer`

## Requirements
- R1: After reset, every byte location is zero, both presence outputs are low, `rd_data` is zero and `notify` is low.
- R2: A host write with `hw_addr` = 0xBC and index `hw_data[15:8]` below 96 stores `hw_data[7:0]` at that index. `hw_data[31:16]` has no effect.
- R3: A byte-load write whose index `hw_data[15:8]` is 96 or higher changes no location.
- R4: A host write with `hw_addr` = 0xBD sets `sink_present` from `hw_data[0]` and `data_valid` from `hw_data[1]` in the next cycle. Other data bits are ignored. Without such a write, both flags hold their value.
- R5: With `rd_en` high and `data_valid` high, `rd_data` in the next cycle equals the byte at `rd_idx`, or zero if `rd_idx` is 96 or higher. While `rd_en` is low, `rd_data` holds its value.
- R6: With `rd_en` high and `data_valid` low, `rd_data` in the next cycle is zero.
- R7: `notify` is high for exactly the one cycle after a presence write whose two bits differ from the current flags. A presence write that repeats the current value raises no pulse.
- R8: Host writes to any other word address change neither the byte store nor the presence flags.
- R9: Writing zero to the presence register clears both flags, as on a disconnect. The stored bytes are kept and become readable again once the valid bit is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Host write strobe |
| hw_addr | input | 8 | Host word address |
| hw_data | input | 32 | Host write data |
| rd_en | input | 1 | Codec read request |
| rd_idx | input | 8 | Codec byte index |
| rd_data | output | 8 | Byte returned one cycle after the request |
| sink_present | output | 1 | Presence flag, bit 0 of the presence register |
| data_valid | output | 1 | Validity flag, bit 1 of the presence register |
| notify | output | 1 | One-cycle pulse on a presence change |

## Verification
The assertions assume that a host write lasts one cycle per strobe and that `hw_addr`, `hw_data`, `rd_en` and `rd_idx` are stable and known at each rising edge. The bench changes all inputs only on falling edges. It holds each strobe for exactly one cycle. Random addresses are taken from the two live addresses, their neighbour and arbitrary values. Random indices run up to 127, so the out-of-range path is exercised together with the in-range one.

// File: rtl/eld_pkg.sv
package eld_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_GONE     = 2'b00,
        ST_ATTACHED = 2'b01,
        ST_STALE    = 2'b10,
        ST_READY    = 2'b11
    } pres_state_t;

    typedef struct packed {
        logic              load_we;
        logic [7:0]        load_idx;
        logic [BYTE_W-1:0] load_byte;
        logic              pres_we;
        logic [1:0]        pres_bits;
    } host_cmd_t;

endpackage

// File: rtl/eld_wr_decode.sv
module eld_wr_decode
    import eld_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 96,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = 8'hBC,
    parameter logic [ADDR_W-1:0] PRES_ADDR = 8'hBD
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output host_cmd_t         cmd
);
    localparam logic [7:0] LIMIT = 8'(DEPTH);

    always_comb begin
        cmd           = '0;
        cmd.load_idx  = data[15:8];
        cmd.load_byte = data[7:0];
        cmd.pres_bits = data[1:0];
        cmd.load_we   = en && (addr == LOAD_ADDR) && (data[15:8] < LIMIT);
        cmd.pres_we   = en && (addr == PRES_ADDR);
    end
endmodule

// File: rtl/eld_store.sv
module eld_store
    import eld_pkg::*;
#(
    parameter int DEPTH = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        widx,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              re,
    input  logic [7:0]        ridx,
    input  logic              use_ok,
    output logic [BYTE_W-1:0] rdata
);
    localparam int         AW    = $clog2(DEPTH);
    localparam logic [7:0] LIMIT = 8'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && widx == 8'(g))
                mem[g] <= wbyte;
        end
    end

    always_comb begin
        sel = '0;
        if (ridx < LIMIT)
            sel = mem[ridx[AW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= use_ok ? sel : '0;
    end
endmodule

// File: rtl/eld_pres_fsm.sv
module eld_pres_fsm
    import eld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] bits,
    output logic       present,
    output logic       valid,
    output logic       notify
);
    pres_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr) begin
            unique case (bits)
                2'b00: state_d = ST_GONE;
                2'b01: state_d = ST_ATTACHED;
                2'b10: state_d = ST_STALE;
                2'b11: state_d = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GONE;
            notify  <= 1'b0;
        end else begin
            state_q <= state_d;
            notify  <= (state_d != state_q);
        end
    end

    always_comb begin
        unique case (state_q)
            ST_GONE:     begin present = 1'b0; valid = 1'b0; end
            ST_ATTACHED: begin present = 1'b1; valid = 1'b0; end
            ST_STALE:    begin present = 1'b0; valid = 1'b1; end
            ST_READY:    begin present = 1'b1; valid = 1'b1; end
        endcase
    end
endmodule

// File: rtl/eld_buffer.sv
module eld_buffer
    import eld_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 96,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = 8'hBC,
    parameter logic [ADDR_W-1:0] PRES_ADDR = 8'hBD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [DATA_W-1:0] hw_data,
    input  logic              rd_en,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic              sink_present,
    output logic              data_valid,
    output logic              notify
);
    host_cmd_t cmd;

    eld_wr_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .LOAD_ADDR(LOAD_ADDR), .PRES_ADDR(PRES_ADDR)
    ) u_dec (
        .en(hw_en), .addr(hw_addr), .data(hw_data), .cmd(cmd)
    );

    eld_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(cmd.load_we), .widx(cmd.load_idx), .wbyte(cmd.load_byte),
        .re(rd_en), .ridx(rd_idx), .use_ok(data_valid), .rdata(rd_data)
    );

    eld_pres_fsm u_pres (
        .clk(clk), .rst_n(rst_n),
        .wr(cmd.pres_we), .bits(cmd.pres_bits),
        .present(sink_present), .valid(data_valid), .notify(notify)
    );
endmodule

// File: rtl/eld_buffer_chk.sv
module eld_buffer_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] PRES_ADDR = 8'hBD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_en,
    input logic [ADDR_W-1:0] hw_addr,
    input logic [DATA_W-1:0] hw_data,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic              sink_present,
    input logic              data_valid,
    input logic              notify
);
    logic pres_wr;
    assign pres_wr = hw_en && (hw_addr == PRES_ADDR);

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pres_wr |=> $stable({data_valid, sink_present}));

    assert_flags_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pres_wr |=> ({data_valid, sink_present} == $past(hw_data[1:0])));

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_invalid_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !data_valid) |=> (rd_data == 8'h00));

    assert_change_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_wr && hw_data[1:0] != {data_valid, sink_present}) |=> notify);

    assert_pulse_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> ({data_valid, sink_present} != $past({data_valid, sink_present})));
endmodule

bind eld_buffer eld_buffer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRES_ADDR(PRES_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_addr(hw_addr),
    .hw_data(hw_data), .rd_en(rd_en), .rd_data(rd_data),
    .sink_present(sink_present), .data_valid(data_valid), .notify(notify)
);

// File: tb/eld_buffer_test.sv
module eld_buffer_test;
    localparam int DEPTH = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0;
    logic [7:0]  hw_addr = '0;
    logic [31:0] hw_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        sink_present, data_valid, notify;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_mem [DEPTH];
    logic [1:0] exp_pres = 2'b00;

    always #4 clk = ~clk;

    eld_buffer uut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_addr(hw_addr),
        .hw_data(hw_data), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .sink_present(sink_present),
        .data_valid(data_valid), .notify(notify)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] idx);
        if (!exp_pres[1]) return 8'h00;
        if (idx >= 8'(DEPTH)) return 8'h00;
        return exp_mem[idx];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d, input string req);
        logic [1:0] old;
        old = exp_pres;
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
        if (a == 8'hBC && d[15:8] < 8'(DEPTH)) exp_mem[d[15:8]] = d[7:0];
        if (a == 8'hBD) exp_pres = d[1:0];
        check({req, " flags"}, {30'd0, data_valid, sink_present}, {30'd0, exp_pres});
        check("R7 notify", {31'd0, notify}, {31'd0, (a == 8'hBD) && (d[1:0] != old)});
    endtask

    task automatic codec_rd(input logic [7:0] idx, input string req);
        logic [7:0] e;
        e = exp_read(idx);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, {24'd0, rd_data}, {24'd0, e});
    endtask

    initial begin
        #1500000;
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        void'($urandom(32'd20240613));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", {24'd0, rd_data}, 32'd0);
        check("R1 flags", {30'd0, data_valid, sink_present}, 32'd0);
        check("R1 notify", {31'd0, notify}, 32'd0);

        // R6 read while invalid
        host_wr(8'hBC, 32'h0000_05A5, "R2");
        codec_rd(8'd5, "R6 invalid read");

        // full load with padding, then presence 11
        for (int i = 0; i < DEPTH; i++)
            host_wr(8'hBC, {16'hFFFF, 8'(i), (i < 20) ? 8'(i * 7 + 3) : 8'h00}, "R2 load");
        host_wr(8'hBD, 32'h0000_0003, "R4");
        check("R1 cleared byte", {24'd0, exp_read(8'd50)}, 32'd0);
        codec_rd(8'd0, "R5 first");
        codec_rd(8'd19, "R2 upper bits ignored");
        codec_rd(8'd95, "R5 last");
        codec_rd(8'd96, "R5 past end");
        // R5 hold with rd_en low
        hold = rd_data;
        repeat (2) @(negedge clk);
        check("R5 hold", {24'd0, rd_data}, {24'd0, hold});

        // R3 out-of-range writes
        host_wr(8'hBC, 32'h0000_60EE, "R3");
        host_wr(8'hBC, 32'h0000_FF11, "R3");
        codec_rd(8'd0, "R3 idx0 untouched");
        codec_rd(8'd96, "R3 read 96");
        // R8 other address
        host_wr(8'hBE, 32'h0000_0377, "R8");
        host_wr(8'h3C, 32'h0000_0000, "R8");
        codec_rd(8'd3, "R8 byte untouched");
        // R7 repeat value, no pulse
        host_wr(8'hBD, 32'hFFFF_FFF3, "R7 repeat");
        // R9 disconnect and restore
        host_wr(8'hBD, 32'h0000_0000, "R9");
        codec_rd(8'd1, "R9 invalid after disconnect");
        host_wr(8'hBD, 32'h0000_0001, "R4 present only");
        codec_rd(8'd1, "R6 present only");
        host_wr(8'hBD, 32'h0000_0002, "R4 valid only");
        codec_rd(8'd1, "R9 bytes kept");
        host_wr(8'hBD, 32'h0000_0003, "R4");

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            int unsigned sel;
            logic [7:0] a;
            sel = $urandom % 10;
            if (sel < 5) begin
                a = ($urandom % 8 == 0) ? 8'($urandom) : 8'hBC;
                host_wr(a, {16'($urandom), 8'($urandom % 128), 8'($urandom)}, "R2 rand");
            end else if (sel == 5) begin
                a = ($urandom % 2 == 0) ? 8'hBE : 8'hBD;
                host_wr(a, ($urandom % 3 == 0) ? $urandom : 32'h3, "R4 rand");
            end else begin
                codec_rd(8'($urandom % 128), "R5 rand");
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule